// File: doc/BRIEF.md
# Page Persistence Classification Map

This block sits in the write path of a non-volatile memory controller. It keeps one bit for every 4KB page of the memory. A bit of 1 marks the page as volatile working memory. A bit of 0 marks it as persistent. After reset every bit is 0, so every page is treated as persistent until software says otherwise. The map is not retained across power loss, and it does not need to be: a page that falls back to persistent is only handled more strictly.

Software changes the map through a small command port. A command sets the bit of one page, clears it, or reads back one aligned 32-bit word of the map. Each cache-line write-back that enters the block has its page number taken from its address. The block looks up that page's bit and passes the request on toward the write queue with the bit attached, one cycle later. Both the write-back input and the tagged output use a valid/ready handshake, so a stalled write queue holds the input back.

Top module: `page_class_map`

## Requirements
- R1: After reset every page reads as persistent (0): every read-back word is zero, out_valid and cfg_rvalid are low, and wb_ready is high.
- R2: cfg_ready is always high. A command with cfg_valid high and cfg_op = 1 (set) writes 1 to the bit of page cfg_page. cfg_op = 2 (clear) writes 0 to it. In both cases the page must be below PAGES.
- R3: A command with cfg_valid high and cfg_op = 3 (read) raises cfg_rvalid for exactly the next cycle. cfg_rdata then holds map word cfg_page >> 5, where bit i is the bit of page (cfg_page >> 5) * 32 + i.
- R4: A write-back is accepted on a cycle where wb_valid and wb_ready are both high. It appears on the output one cycle later. out_volatile is the map bit of page wb_addr >> 12.
- R5: A write-back accepted in the same cycle as a set or clear of its own page is tagged with the new value.
- R6: A page number at or above PAGES always counts as persistent. Write-backs to such a page are tagged 0, and a set or clear of such a page changes nothing. Map bits beyond PAGES read back as 0.
- R7: While out_valid is high and out_ready is low, the output stays stable and wb_ready is low. Otherwise wb_ready is high.
- R8: out_addr and out_data equal the accepted wb_addr and wb_data, and requests leave in the order they were accepted.
- R9: A command with cfg_valid low, or with cfg_op = 0 (no operation), leaves the map unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_valid | input | 1 | Command valid |
| cfg_ready | output | 1 | Command accepted (always high) |
| cfg_op | input | 2 | Command: 0 none, 1 set, 2 clear, 3 read word |
| cfg_page | input | ADDR_W-PAGE_SHIFT | Page number; for a read, the word is cfg_page >> 5 |
| cfg_rvalid | output | 1 | Read-back data valid |
| cfg_rdata | output | 32 | Read-back map word |
| wb_valid | input | 1 | Write-back request valid |
| wb_ready | output | 1 | Write-back request accepted |
| wb_addr | input | ADDR_W | Cache-line byte address |
| wb_data | input | DATA_W | Write-back payload |
| out_valid | output | 1 | Tagged request valid |
| out_ready | input | 1 | Write queue can take a request |
| out_addr | output | ADDR_W | Forwarded address |
| out_data | output | DATA_W | Forwarded payload |
| out_volatile | output | 1 | 1 = working page, 0 = persistent page |

## Verification
Write-backs are aimed at a small set of hot pages that commands keep flipping, so tags are checked both before and after each change. A set or clear of the same page in the same cycle separates a tag taken from the stored bit from one taken with the update forwarded. Addresses just above the last page and far beyond it test the out-of-range rule for lookups, updates and read-back. Random output stalls show whether a held request stays stable and whether request order is kept. Directed no-operation commands, and commands with valid low, check that these leave the map as it was.

// File: rtl/pcm_pkg.sv
package pcm_pkg;
  typedef enum logic [1:0] {
    OP_NOP  = 2'd0,
    OP_SET  = 2'd1,
    OP_CLR  = 2'd2,
    OP_READ = 2'd3
  } map_op_e;

  localparam int WORD_BITS = 32;
endpackage

// File: rtl/page_bitmap_store.sv
module page_bitmap_store
  import pcm_pkg::*;
#(
  parameter int PAGES = 1024,
  parameter int PN_W  = 20
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            upd_valid,
  input  map_op_e         upd_op,
  input  logic [PN_W-1:0] upd_page,
  input  logic [PN_W-1:0] lk_page,
  output logic            lk_bit,
  output logic            rd_valid,
  output logic [31:0]     rd_data
);
  localparam int IDX_W = (PAGES > 1) ? $clog2(PAGES) : 1;

  logic [PAGES-1:0] map_q, map_d;
  logic             map_en;
  logic             upd_in_rng, lk_in_rng;
  logic [IDX_W-1:0] upd_idx;
  logic             rd_valid_q, rd_valid_d;
  logic [31:0]      rd_data_q, rd_data_d;
  logic             rd_en;

  assign upd_in_rng = (upd_page < PN_W'(PAGES));
  assign lk_in_rng  = (lk_page < PN_W'(PAGES));
  assign upd_idx    = upd_page[IDX_W-1:0];

  // next-state of the map
  always_comb begin
    map_d  = map_q;
    map_en = 1'b0;
    if (upd_valid && upd_in_rng) begin
      case (upd_op)
        OP_SET: begin map_d[upd_idx] = 1'b1; map_en = 1'b1; end
        OP_CLR: begin map_d[upd_idx] = 1'b0; map_en = 1'b1; end
        default: ;
      endcase
    end
  end

  // lookup sees this cycle's update (forwarded next-state)
  assign lk_bit = lk_in_rng & map_d[lk_page[IDX_W-1:0]];

  // read-back word
  always_comb begin
    logic [PN_W-1:0] bi;
    rd_data_d = '0;
    for (int i = 0; i < WORD_BITS; i++) begin
      bi = {upd_page[PN_W-1:5], 5'(i)};
      if (bi < PN_W'(PAGES)) rd_data_d[i] = map_q[bi[IDX_W-1:0]];
    end
    rd_valid_d = upd_valid && (upd_op == OP_READ);
    rd_en      = rd_valid_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      map_q      <= '0;
      rd_valid_q <= 1'b0;
      rd_data_q  <= '0;
    end else begin
      rd_valid_q <= rd_valid_d;
      if (map_en) map_q <= map_d;
      if (rd_en)  rd_data_q <= rd_data_d;
    end
  end

  assign rd_valid = rd_valid_q;
  assign rd_data  = rd_data_q;

  AST_MAP_CLEAR_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (map_q == '0)); // R1
  AST_SET_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && upd_op == OP_SET && upd_in_rng) |=> map_q[$past(upd_idx)]); // R2
  AST_CLR_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && upd_op == OP_CLR && upd_in_rng) |=> !map_q[$past(upd_idx)]); // R2
  AST_READ_RESPONDS: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && upd_op == OP_READ) |=> rd_valid); // R3
  AST_OOR_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && !upd_in_rng) |=> $stable(map_q)); // R6
  AST_IDLE_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (!upd_valid || upd_op == OP_NOP || upd_op == OP_READ) |=> $stable(map_q)); // R9
endmodule

// File: rtl/wb_tag_stage.sv
module wb_tag_stage #(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 64,
  parameter int PAGE_SHIFT = 12,
  localparam int PN_W      = ADDR_W - PAGE_SHIFT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [DATA_W-1:0] in_data,
  output logic [PN_W-1:0]   page_no,
  input  logic              vol_bit,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [ADDR_W-1:0] out_addr,
  output logic [DATA_W-1:0] out_data,
  output logic              out_vol
);
  logic              vld_q, vld_d;
  logic              load;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic              vol_q;

  assign page_no  = in_addr[ADDR_W-1:PAGE_SHIFT];
  assign in_ready = !vld_q || out_ready;

  always_comb begin
    load  = in_valid && in_ready;
    vld_d = vld_q;
    if (load)           vld_d = 1'b1;
    else if (out_ready) vld_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
      vol_q  <= 1'b0;
    end else begin
      vld_q <= vld_d;
      if (load) begin
        addr_q <= in_addr;
        data_q <= in_data;
        vol_q  <= vol_bit;
      end
    end
  end

  assign out_valid = vld_q;
  assign out_addr  = addr_q;
  assign out_data  = data_q;
  assign out_vol   = vol_q;

  AST_HOLD_WHILE_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_addr) && $stable(out_data)
                                   && $stable(out_vol))); // R7
  AST_ONE_CYCLE_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (out_valid && out_addr == $past(in_addr)
                                && out_data == $past(in_data))); // R8
endmodule

// File: rtl/page_class_map.sv
module page_class_map
  import pcm_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 64,
  parameter int PAGES      = 1024,
  parameter int PAGE_SHIFT = 12
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         cfg_valid,
  output logic                         cfg_ready,
  input  logic [1:0]                   cfg_op,
  input  logic [ADDR_W-PAGE_SHIFT-1:0] cfg_page,
  output logic                         cfg_rvalid,
  output logic [31:0]                  cfg_rdata,
  input  logic                         wb_valid,
  output logic                         wb_ready,
  input  logic [ADDR_W-1:0]            wb_addr,
  input  logic [DATA_W-1:0]            wb_data,
  output logic                         out_valid,
  input  logic                         out_ready,
  output logic [ADDR_W-1:0]            out_addr,
  output logic [DATA_W-1:0]            out_data,
  output logic                         out_volatile
);
  localparam int PN_W = ADDR_W - PAGE_SHIFT;

  logic [PN_W-1:0] lk_page;
  logic            lk_bit;
  map_op_e         op;

  assign op        = map_op_e'(cfg_op);
  assign cfg_ready = 1'b1;

  page_bitmap_store #(.PAGES(PAGES), .PN_W(PN_W)) store_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .upd_valid (cfg_valid),
    .upd_op    (op),
    .upd_page  (cfg_page),
    .lk_page   (lk_page),
    .lk_bit    (lk_bit),
    .rd_valid  (cfg_rvalid),
    .rd_data   (cfg_rdata)
  );

  wb_tag_stage #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_SHIFT(PAGE_SHIFT)) tag_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (wb_valid),
    .in_ready  (wb_ready),
    .in_addr   (wb_addr),
    .in_data   (wb_data),
    .page_no   (lk_page),
    .vol_bit   (lk_bit),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_addr  (out_addr),
    .out_data  (out_data),
    .out_vol   (out_volatile)
  );

  AST_OOR_PERSISTENT: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_addr[ADDR_W-1:PAGE_SHIFT] >= PN_W'(PAGES)) |-> !out_volatile); // R6
  AST_SAME_CYCLE_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_valid && wb_ready && cfg_valid && op == OP_SET && cfg_page < PN_W'(PAGES)
     && cfg_page == wb_addr[ADDR_W-1:PAGE_SHIFT]) |=> out_volatile); // R5
  AST_SAME_CYCLE_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_valid && wb_ready && cfg_valid && op == OP_CLR
     && cfg_page == wb_addr[ADDR_W-1:PAGE_SHIFT]) |=> !out_volatile); // R5
  AST_READY_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (wb_ready && !out_valid)); // R1
endmodule

// File: tb/page_class_map_tb_top.sv
module page_class_map_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 32;
  localparam int DATA_W     = 64;
  localparam int PAGES      = 1024;
  localparam int PAGE_SHIFT = 12;
  localparam int PN_W       = ADDR_W - PAGE_SHIFT;

  localparam logic [1:0] C_NOP = 2'd0, C_SET = 2'd1, C_CLR = 2'd2, C_RD = 2'd3;

  logic              clk, rst_n;
  logic              cfg_valid, cfg_ready, cfg_rvalid;
  logic [1:0]        cfg_op;
  logic [PN_W-1:0]   cfg_page;
  logic [31:0]       cfg_rdata;
  logic              wb_valid, wb_ready, out_valid, out_ready, out_volatile;
  logic [ADDR_W-1:0] wb_addr, out_addr;
  logic [DATA_W-1:0] wb_data, out_data;

  page_class_map #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGES(PAGES), .PAGE_SHIFT(PAGE_SHIFT)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_ready(cfg_ready), .cfg_op(cfg_op),
    .cfg_page(cfg_page), .cfg_rvalid(cfg_rvalid), .cfg_rdata(cfg_rdata), .wb_valid(wb_valid),
    .wb_ready(wb_ready), .wb_addr(wb_addr), .wb_data(wb_data), .out_valid(out_valid),
    .out_ready(out_ready), .out_addr(out_addr), .out_data(out_data), .out_volatile(out_volatile)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    logic [ADDR_W-1:0] a;
    logic [DATA_W-1:0] d;
    logic              v;
    string             tag;
  } exp_t;

  logic        model_map [PAGES];
  exp_t        exp_q [$];
  logic        rd_pending;
  logic [31:0] rd_exp;
  string       rd_tag;
  logic        stall_prev;
  logic [ADDR_W-1:0] s_a;
  logic [DATA_W-1:0] s_d;
  logic        s_v;
  int          n_chk, n_fail;

  function automatic logic [31:0] model_word(input logic [PN_W-1:0] pg);
    logic [31:0] w;
    logic [PN_W-1:0] idx;
    w = '0;
    for (int i = 0; i < 32; i++) begin
      idx = {pg[PN_W-1:5], 5'(i)};
      if (idx < PN_W'(PAGES)) w[i] = model_map[int'(idx)];
    end
    return w;
  endfunction

  function automatic logic model_bit(input logic [PN_W-1:0] pg);
    if (pg >= PN_W'(PAGES)) return 1'b0;
    return model_map[int'(pg)];
  endfunction

  function automatic logic [PN_W-1:0] pick_page();
    int r;
    r = int'($urandom % 10);
    if (r < 6)      return PN_W'($urandom % 32);
    else if (r < 8) return PN_W'($urandom % PAGES);
    else if (r < 9) return PN_W'(PAGES + ($urandom % 8));
    else            return PN_W'($urandom);
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, expv);
    end
  endtask

  task automatic cycle(input logic [1:0] op, input logic cvalid, input logic [PN_W-1:0] cpage,
                       input logic wvalid, input logic [ADDR_W-1:0] waddr,
                       input logic oready, input string rtag);
    exp_t e;
    logic [PN_W-1:0] wpg;
    @(negedge clk);
    check(cfg_rvalid == rd_pending, "R3", "read valid", 64'(cfg_rvalid), 64'(rd_pending));
    if (rd_pending) check(cfg_rdata == rd_exp, rd_tag, "read data", 64'(cfg_rdata), 64'(rd_exp));
    rd_pending = 1'b0;
    if (stall_prev)
      check(out_valid && out_addr == s_a && out_data == s_d && out_volatile == s_v,
            "R7", "held output", 64'(out_addr), 64'(s_a));
    out_ready = oready; cfg_valid = cvalid; cfg_op = op; cfg_page = cpage;
    wb_valid = wvalid; wb_addr = waddr; wb_data = {$urandom, $urandom};
    #1;
    check(cfg_ready == 1'b1, "R2", "cfg_ready", 64'(cfg_ready), 64'd1);
    check(wb_ready == (!out_valid || out_ready), "R7", "wb_ready", 64'(wb_ready),
          64'(!out_valid || out_ready));
    if (out_valid && out_ready) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R8", "unexpected output", 64'(out_addr), 64'd0);
      end else begin
        e = exp_q.pop_front();
        check(out_addr == e.a, "R8", "addr", 64'(out_addr), 64'(e.a));
        check(out_data == e.d, "R8", "data", out_data, e.d);
        check(out_volatile == e.v, e.tag, "volatile tag", 64'(out_volatile), 64'(e.v));
      end
    end
    stall_prev = out_valid && !out_ready;
    s_a = out_addr; s_d = out_data; s_v = out_volatile;
    if (cvalid) begin
      if (op == C_RD) begin
        rd_pending = 1'b1; rd_exp = model_word(cpage); rd_tag = rtag;
      end else if (op == C_SET && cpage < PN_W'(PAGES)) model_map[int'(cpage)] = 1'b1;
      else if (op == C_CLR && cpage < PN_W'(PAGES)) model_map[int'(cpage)] = 1'b0;
    end
    if (wvalid && wb_ready) begin
      wpg = waddr[ADDR_W-1:PAGE_SHIFT];
      e.a = waddr; e.d = wb_data; e.v = model_bit(wpg);
      if (wpg >= PN_W'(PAGES)) e.tag = "R6";
      else if (cvalid && (op == C_SET || op == C_CLR) && cpage == wpg) e.tag = "R5";
      else e.tag = "R4";
      exp_q.push_back(e);
    end
  endtask

  function automatic logic [ADDR_W-1:0] addr_of(input logic [PN_W-1:0] pg);
    return {pg, PAGE_SHIFT'($urandom & 32'hFC0)};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0C1A));
    n_chk = 0; n_fail = 0; rd_pending = 1'b0; stall_prev = 1'b0;
    for (int i = 0; i < PAGES; i++) model_map[i] = 1'b0;
    rst_n = 1'b0; cfg_valid = 1'b0; cfg_op = C_NOP; cfg_page = '0;
    wb_valid = 1'b0; wb_addr = '0; wb_data = '0; out_ready = 1'b1;
    repeat (3) @(negedge clk);
    check(!out_valid, "R1", "out_valid in reset", 64'(out_valid), 64'd0);
    check(!cfg_rvalid, "R1", "cfg_rvalid in reset", 64'(cfg_rvalid), 64'd0);
    check(wb_ready, "R1", "wb_ready in reset", 64'(wb_ready), 64'd1);
    rst_n = 1'b1;

    // R1: reset contents read as zero
    cycle(C_RD, 1, PN_W'(0), 1, addr_of(PN_W'(3)), 1, "R1");
    cycle(C_RD, 1, PN_W'(31*32), 0, '0, 1, "R1");
    // R2: set then clear
    cycle(C_SET, 1, PN_W'(5), 0, '0, 1, "");
    cycle(C_RD, 1, PN_W'(5), 1, addr_of(PN_W'(5)), 1, "R2");
    cycle(C_SET, 1, PN_W'(PAGES-1), 0, '0, 1, "");
    cycle(C_RD, 1, PN_W'(PAGES-1), 1, addr_of(PN_W'(PAGES-1)), 1, "R2");
    cycle(C_CLR, 1, PN_W'(5), 0, '0, 1, "");
    cycle(C_RD, 1, PN_W'(5), 1, addr_of(PN_W'(5)), 1, "R2");
    // R9: no-op command and command without valid
    cycle(C_NOP, 1, PN_W'(7), 0, '0, 1, "");
    cycle(C_SET, 0, PN_W'(8), 0, '0, 1, "");
    cycle(C_RD, 1, PN_W'(7), 0, '0, 1, "R9");
    // R6: out-of-range set ignored, lookups persistent
    cycle(C_SET, 1, PN_W'(PAGES), 1, addr_of(PN_W'(PAGES)), 1, "");
    cycle(C_SET, 1, PN_W'(70000), 1, addr_of(PN_W'(70000)), 1, "");
    cycle(C_RD, 1, PN_W'(PAGES), 1, addr_of(PN_W'(PAGES)), 1, "R6");
    cycle(C_RD, 1, PN_W'(0), 0, '0, 1, "R6");
    // R5: same-cycle update is seen by the lookup
    cycle(C_SET, 1, PN_W'(9), 1, addr_of(PN_W'(9)), 1, "");
    cycle(C_CLR, 1, PN_W'(9), 1, addr_of(PN_W'(9)), 1, "");
    cycle(C_SET, 1, PN_W'(9), 1, addr_of(PN_W'(9)), 1, "");
    // R7: stall for several cycles
    cycle(C_NOP, 0, '0, 1, addr_of(PN_W'(9)), 0, "");
    cycle(C_NOP, 0, '0, 1, addr_of(PN_W'(10)), 0, "");
    cycle(C_NOP, 0, '0, 1, addr_of(PN_W'(11)), 0, "");
    cycle(C_NOP, 0, '0, 1, addr_of(PN_W'(12)), 1, "");
    cycle(C_NOP, 0, '0, 0, '0, 1, "");

    // random mix, R3/R4/R8
    for (int n = 0; n < 4000; n++) begin
      logic [1:0] op;
      op = 2'($urandom % 4);
      cycle(op, ($urandom % 4) != 0, pick_page(), ($urandom % 3) != 0,
            addr_of(pick_page()), ($urandom % 4) != 0, "R3");
    end
    repeat (4) cycle(C_NOP, 0, '0, 0, '0, 1, "R3");
    check(exp_q.size() == 0, "R8", "pending outputs", 64'(exp_q.size()), 64'd0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule